// File: doc/BRIEF.md
# Virtual CPU Maintenance Interrupt Generator

This block serves one virtual CPU of a hypervisor-assisted interrupt controller. It watches the list-register slots that hold virtual interrupts for that CPU, along with each slot's end-of-interrupt notify flag and the two group enables of the virtual machine's CPU interface. From these it forms three status words: an 8-bit maintenance status word, a bitmap of empty slots, and a bitmap of slots that owe the hypervisor an end-of-interrupt notification.

When the control register's global enable is set and any maintenance condition holds, the block raises a maintenance interrupt request toward the physical interrupt controller. The hypervisor services that request by reading the status words through a small word-addressed register port. The same port lets it program a control register, which holds the global enable, one interrupt enable per maintenance condition, and an end-of-interrupt count.

Each status word is a pure function of the present inputs and the control register. Only the request line is registered.

Top module: `mi_maint_gen`

## Requirements
- R1: Slot state uses 2 bits per slot, with slot i at `lr_state[2*i+1:2*i]`: 00 invalid, 01 pending, 10 active, 11 pending and active. Bit i of `empty_map` is 1 exactly when slot i is invalid.
- R2: Bit i of `eoi_map` is 1 exactly when slot i is invalid and `lr_eoi_notify[i]` is 1. The bit clears as soon as the slot holds a non-invalid state or its notify flag drops.
- R3: Status bit 0 is 1 whenever any bit of `eoi_map` is 1, whatever the enables.
- R4: Status bit 7 is 1 when control bit 7 (group-1 disabled interrupt enable) is set and `vm_grp1_en` is 0. Status bit 6 is 1 when control bit 6 (group-1 enabled interrupt enable) is set and `vm_grp1_en` is 1.
- R5: Status bits 5 and 4 follow the rule of R4 for group 0, using control bits 5 and 4 and `vm_grp0_en`.
- R6: Status bit 3 is 1 when control bit 3 is set and no slot has state 01 or 11.
- R7: Status bit 2 is 1 when control bit 2 is set and the end-of-interrupt count in control bits [15:8] is nonzero.
- R8: Status bit 1 is 1 when control bit 1 is set and at most one slot holds a non-invalid state.
- R9: `maint_irq` is registered. It equals control bit 0 AND (status word nonzero) as sampled at the previous rising clock edge, so it changes one clock after its inputs change.
- R10: After reset, the control register is 0 and `maint_irq` is 0.
- R11: The register map is word-addressed by `reg_addr`: 0 control (read/write), 1 status (read-only), 2 end-of-interrupt bitmap (read-only), 3 empty bitmap (read-only). Reads are combinational and zero-extended. A write to address 1, 2 or 3 changes neither the control register nor any status word.
- R12: The 16-bit control word is stored whole and reads back exactly as written. Bit 0 is the global enable, bits 7..1 are the condition enables of R4 to R8, and bits [15:8] are the end-of-interrupt count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_state | input | 2*NUM_LR | Packed per-slot states, slot 0 in the low bits |
| lr_eoi_notify | input | NUM_LR | Per-slot end-of-interrupt notify flag |
| vm_grp0_en | input | 1 | Virtual CPU interface group-0 enable |
| vm_grp1_en | input | 1 | Virtual CPU interface group-1 enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mstat | output | 8 | Maintenance status word |
| empty_map | output | NUM_LR | Empty-slot bitmap |
| eoi_map | output | NUM_LR | End-of-interrupt status bitmap |
| maint_irq | output | 1 | Registered maintenance interrupt request |

## Verification
Every status word is combinational. A wrong slot decode, popcount or enable gating therefore shows on `mstat`, `empty_map` or `eoi_map` in the same cycle as the stimulus, and on `reg_rdata` as soon as that word is addressed. A fault in the control register shows on the next edge, either on its readback or on the gated status bits. A fault in the request flop shows one clock after the status changes, as a missing, early or stuck `maint_irq`. The bench therefore samples each word in the cycle it is driven and checks the request on both sides of the edge that updates it.

// File: rtl/mi_pkg.sv
package mi_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int STAT_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_EOI   = 2'd2;
  localparam logic [ADDR_W-1:0] A_EMPTY = 2'd3;

  typedef enum logic [1:0] {
    SLOT_INVALID  = 2'b00,
    SLOT_PENDING  = 2'b01,
    SLOT_ACTIVE   = 2'b10,
    SLOT_PEND_ACT = 2'b11
  } slot_state_e;

  // Control word, bit 0 at the bottom.
  typedef struct packed {
    logic [7:0] eoi_cnt;    // [15:8]
    logic       g1_off_ie;  // 7
    logic       g1_on_ie;   // 6
    logic       g0_off_ie;  // 5
    logic       g0_on_ie;   // 4
    logic       nopend_ie;  // 3
    logic       eoicnt_ie;  // 2
    logic       under_ie;   // 1
    logic       en;         // 0
  } hv_ctrl_t;

  // Status bit positions.
  localparam int S_EOI    = 0;
  localparam int S_UNDER  = 1;
  localparam int S_EOICNT = 2;
  localparam int S_NOPEND = 3;
  localparam int S_G0ON   = 4;
  localparam int S_G0OFF  = 5;
  localparam int S_G1ON   = 6;
  localparam int S_G1OFF  = 7;

  function automatic logic slot_is_empty(input logic [1:0] st);
    return st == SLOT_INVALID;
  endfunction

  function automatic logic slot_is_pending(input logic [1:0] st);
    return st[0];
  endfunction

  function automatic logic [STAT_W-1:0] status_word(
    input hv_ctrl_t c,
    input logic     g0,
    input logic     g1,
    input logic     any_pend,
    input logic     few_valid,
    input logic     eoi_any
  );
    logic [STAT_W-1:0] s;
    s           = '0;
    s[S_G1OFF]  = c.g1_off_ie & ~g1;
    s[S_G1ON]   = c.g1_on_ie  &  g1;
    s[S_G0OFF]  = c.g0_off_ie & ~g0;
    s[S_G0ON]   = c.g0_on_ie  &  g0;
    s[S_NOPEND] = c.nopend_ie & ~any_pend;
    s[S_EOICNT] = c.eoicnt_ie & (c.eoi_cnt != 8'd0);
    s[S_UNDER]  = c.under_ie  &  few_valid;
    s[S_EOI]    = eoi_any;
    return s;
  endfunction

endpackage

// File: rtl/mi_slot_scan.sv
module mi_slot_scan
  import mi_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input  logic [2*NUM_LR-1:0] lr_state,
  input  logic [NUM_LR-1:0]   lr_eoi_notify,
  output logic [NUM_LR-1:0]   empty_map,
  output logic [NUM_LR-1:0]   pend_map,
  output logic [NUM_LR-1:0]   eoi_map,
  output logic [CNT_W-1:0]    valid_cnt
);

  function automatic logic [CNT_W-1:0] count_ones(input logic [NUM_LR-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int k = 0; k < NUM_LR; k++) begin
      n = n + CNT_W'(v[k]);
    end
    return n;
  endfunction

  for (genvar i = 0; i < NUM_LR; i++) begin : g_slot
    logic [1:0] st;
    assign st           = lr_state[2*i +: 2];
    assign empty_map[i] = slot_is_empty(st);
    assign pend_map[i]  = slot_is_pending(st);
    assign eoi_map[i]   = slot_is_empty(st) & lr_eoi_notify[i];
  end

  assign valid_cnt = count_ones(~empty_map);

endmodule

// File: rtl/mi_status_calc.sv
module mi_status_calc
  import mi_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int CNT_W = $clog2(NUM_LR + 1)
) (
  input  hv_ctrl_t            ctrl,
  input  logic                vm_grp0_en,
  input  logic                vm_grp1_en,
  input  logic [NUM_LR-1:0]   pend_map,
  input  logic [NUM_LR-1:0]   eoi_map,
  input  logic [CNT_W-1:0]    valid_cnt,
  output logic [STAT_W-1:0]   mstat,
  output logic                raise_req
);

  logic any_pend;
  logic few_valid;
  logic eoi_any;

  assign any_pend  = |pend_map;
  assign few_valid = valid_cnt <= CNT_W'(1);
  assign eoi_any   = |eoi_map;

  assign mstat     = status_word(ctrl, vm_grp0_en, vm_grp1_en,
                                 any_pend, few_valid, eoi_any);
  assign raise_req = ctrl.en & (|mstat);

endmodule

// File: rtl/mi_ctrl_regs.sv
module mi_ctrl_regs
  import mi_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [STAT_W-1:0] mstat,
  input  logic [NUM_LR-1:0] eoi_map,
  input  logic [NUM_LR-1:0] empty_map,
  output hv_ctrl_t          ctrl,
  output logic [DATA_W-1:0] reg_rdata
);

  logic ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl <= hv_ctrl_t'(reg_wdata);
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl);
      A_STAT:  reg_rdata = DATA_W'(mstat);
      A_EOI:   reg_rdata = DATA_W'(eoi_map);
      default: reg_rdata = DATA_W'(empty_map);
    endcase
  end

endmodule

// File: rtl/mi_maint_gen.sv
module mi_maint_gen
  import mi_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_LR-1:0]   lr_state,
  input  logic [NUM_LR-1:0]     lr_eoi_notify,
  input  logic                  vm_grp0_en,
  input  logic                  vm_grp1_en,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [STAT_W-1:0]     mstat,
  output logic [NUM_LR-1:0]     empty_map,
  output logic [NUM_LR-1:0]     eoi_map,
  output logic                  maint_irq
);

  localparam int CNT_W = $clog2(NUM_LR + 1);

  // Named internal events, visible to the bound checker.
  hv_ctrl_t          ctrl_q;
  logic [NUM_LR-1:0] pend_map;
  logic [CNT_W-1:0]  valid_cnt;
  logic              raise_req;
  logic              hv_en;

  assign hv_en = ctrl_q.en;

  mi_slot_scan #(.NUM_LR(NUM_LR)) u_scan (
    .lr_state      (lr_state),
    .lr_eoi_notify (lr_eoi_notify),
    .empty_map     (empty_map),
    .pend_map      (pend_map),
    .eoi_map       (eoi_map),
    .valid_cnt     (valid_cnt)
  );

  mi_status_calc #(.NUM_LR(NUM_LR)) u_calc (
    .ctrl       (ctrl_q),
    .vm_grp0_en (vm_grp0_en),
    .vm_grp1_en (vm_grp1_en),
    .pend_map   (pend_map),
    .eoi_map    (eoi_map),
    .valid_cnt  (valid_cnt),
    .mstat      (mstat),
    .raise_req  (raise_req)
  );

  mi_ctrl_regs #(.NUM_LR(NUM_LR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mstat     (mstat),
    .eoi_map   (eoi_map),
    .empty_map (empty_map),
    .ctrl      (ctrl_q),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maint_irq <= 1'b0;
    end else begin
      maint_irq <= raise_req;
    end
  end

endmodule

// File: rtl/mi_maint_gen_chk.sv
module mi_maint_gen_chk
  import mi_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hv_en,
  input logic [DATA_W-1:0] ctrl_word,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [STAT_W-1:0] mstat,
  input logic [NUM_LR-1:0] empty_map,
  input logic [NUM_LR-1:0] eoi_map,
  input logic [NUM_LR-1:0] pend_map,
  input logic              maint_irq
);

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en && (mstat != '0)) |=> maint_irq);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_en && (mstat != '0)) |=> !maint_irq);

  assert_eoi_only_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_map & ~empty_map) == '0);

  assert_eoi_summary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mstat[S_EOI] == (|eoi_map));

  assert_grp1_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mstat[S_G1ON] && mstat[S_G1OFF]));

  assert_grp0_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mstat[S_G0ON] && mstat[S_G0OFF]));

  assert_nopend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mstat[S_NOPEND] |-> (pend_map == '0));

  assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mstat[S_UNDER] |-> ($countones(~empty_map) <= 1));

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == A_CTRL)) |=> $stable(ctrl_word));

endmodule

bind mi_maint_gen mi_maint_gen_chk #(.NUM_LR(NUM_LR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hv_en     (hv_en),
  .ctrl_word (ctrl_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .mstat     (mstat),
  .empty_map (empty_map),
  .eoi_map   (eoi_map),
  .pend_map  (pend_map),
  .maint_irq (maint_irq)
);

// File: tb/tb_mi_maint_gen.sv
`timescale 1ns/1ps
module tb_mi_maint_gen;

  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*N-1:0] lr_state = '0;
  logic [N-1:0]  lr_eoi_notify = '0;
  logic          vm_grp0_en = 1'b0;
  logic          vm_grp1_en = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [7:0]    mstat;
  logic [N-1:0]  empty_map;
  logic [N-1:0]  eoi_map;
  logic          maint_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mi_maint_gen #(.NUM_LR(N)) dut (
    .clk(clk), .rst_n(rst_n), .lr_state(lr_state), .lr_eoi_notify(lr_eoi_notify),
    .vm_grp0_en(vm_grp0_en), .vm_grp1_en(vm_grp1_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mstat(mstat), .empty_map(empty_map), .eoi_map(eoi_map), .maint_irq(maint_irq)
  );

  typedef struct packed {
    logic [15:0] ctrl;
    logic [7:0]  st;
    logic [3:0]  nt;
    logic        g0;
    logic        g1;
    logic [7:0]  xst;
    logic [3:0]  xempty;
    logic [3:0]  xeoi;
    logic        xirq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{16'h00FF, 8'h00, 4'h0, 1'b0, 1'b0, 8'hAA, 4'hF, 4'h0, 1'b1},
    '{16'h00FF, 8'h39, 4'h8, 1'b1, 1'b1, 8'h51, 4'h8, 4'h8, 1'b1},
    '{16'h0000, 8'h39, 4'h8, 1'b1, 1'b1, 8'h01, 4'h8, 4'h8, 1'b0},
    '{16'h0305, 8'h02, 4'h0, 1'b1, 1'b0, 8'h04, 4'hE, 4'h0, 1'b1},
    '{16'h0003, 8'h02, 4'h1, 1'b0, 1'b0, 8'h02, 4'hE, 4'h0, 1'b1},
    '{16'h0003, 8'h0A, 4'hC, 1'b0, 1'b0, 8'h01, 4'hC, 4'hC, 1'b1},
    '{16'h0009, 8'h88, 4'h0, 1'b0, 1'b0, 8'h08, 4'h5, 4'h0, 1'b1},
    '{16'h0001, 8'hFF, 4'hF, 1'b1, 1'b1, 8'h00, 4'h0, 4'h0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [15:0] exp, input string req);
    reg_addr = a;
    #0.1;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq after reset", 32'(maint_irq), 32'd0);
    read_chk(2'd0, 16'h0000, "R10 ctrl after reset");

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      reg_write(2'd0, VEC[v].ctrl);
      lr_state      = VEC[v].st;
      lr_eoi_notify = VEC[v].nt;
      vm_grp0_en    = VEC[v].g0;
      vm_grp1_en    = VEC[v].g1;
      @(negedge clk);
      check("R1/R4-R8 mstat", 32'(mstat), 32'(VEC[v].xst));
      check("R1 empty_map", 32'(empty_map), 32'(VEC[v].xempty));
      check("R2 eoi_map", 32'(eoi_map), 32'(VEC[v].xeoi));
      check("R9 maint_irq", 32'(maint_irq), 32'(VEC[v].xirq));
      read_chk(2'd0, VEC[v].ctrl, "R12 ctrl readback");
      read_chk(2'd1, 16'(VEC[v].xst), "R11 status read");
      read_chk(2'd2, 16'(VEC[v].xeoi), "R11 eoi read");
      read_chk(2'd3, 16'(VEC[v].xempty), "R11 empty read");
    end

    // R9 latency: status rises with ctrl write, irq follows one edge later
    reg_write(2'd0, 16'h0000);
    lr_state = 8'h00; lr_eoi_notify = 4'h0;
    @(negedge clk);
    check("R9 irq low before", 32'(maint_irq), 32'd0);
    reg_addr = 2'd0; reg_wdata = 16'h0009; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    check("R6 nopend status", 32'(mstat), 32'h08);
    check("R9 irq not yet", 32'(maint_irq), 32'd0);
    @(negedge clk);
    check("R9 irq one clock later", 32'(maint_irq), 32'd1);
    reg_addr = 2'd0; reg_wdata = 16'h0008; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    check("R9 irq holds one clock", 32'(maint_irq), 32'd1);
    @(negedge clk);
    check("R9 irq drops", 32'(maint_irq), 32'd0);

    // R11 writes to read-only words are ignored
    reg_write(2'd0, 16'h00A5);
    lr_state = 8'h40; lr_eoi_notify = 4'hF;   // slot3 pending, slots 0-2 empty+notify
    reg_write(2'd2, 16'hFFFF);
    reg_write(2'd1, 16'h0000);
    reg_write(2'd3, 16'h0000);
    check("R11 eoi unchanged by write", 32'(eoi_map), 32'h7);
    check("R11 empty unchanged by write", 32'(empty_map), 32'h7);
    read_chk(2'd0, 16'h00A5, "R11 ctrl unchanged by ro writes");

    // R2 clear: reload slot 0, drop notify of slot 1
    lr_state = 8'h41; lr_eoi_notify = 4'hD;
    #0.1;
    check("R2 eoi clears", 32'(eoi_map), 32'h4);
    check("R3 eoi summary", 32'(mstat[0]), 32'd1);
    lr_eoi_notify = 4'h0;
    #0.1;
    check("R3 eoi summary clear", 32'(mstat[0]), 32'd0);

    // R7 count nonzero only in top byte
    reg_write(2'd0, 16'h8004);
    check("R7 count msb", 32'(mstat), 32'h04);
    reg_write(2'd0, 16'h00FC & 16'h0004);
    check("R7 count zero", 32'(mstat), 32'h00);

    // R8 boundary: exactly two valid slots vs one
    reg_write(2'd0, 16'h0002);
    lr_state = 8'h05; #0.1;
    check("R8 two valid", 32'(mstat), 32'h00);
    lr_state = 8'h04; #0.1;
    check("R8 one valid", 32'(mstat), 32'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule